// File: doc/BRIEF.md
# Cascadable Presettable 4-Bit Counter

This block is a synchronous counter stage with a parallel preset, an active-low clear and two count enables. Two elaboration parameters fix its character: `DECADE` picks a modulus of ten (last state 9) or of sixteen (last state 15), and `ASYNC_CLR` makes the clear act either at the next rising clock edge or at once, without waiting for the clock.

The two enables play different roles. `cnt_en` only takes part in counting. `chain_en` takes part in counting and also gates the carry output. The carry output is high while the stage sits at its last state and `chain_en` is high. Because the carry is combinational from the stored count, several stages that share clock, load and `cnt_en` form a wider synchronous counter when each stage's carry drives the next stage's `chain_en`.

Clear beats load, and load beats counting. A synchronous active-high `rst` also zeroes the count at a clock edge.

Top module: `casc_counter`

## Requirements
- R1: With `rst` high at a rising edge, `q` becomes 0 after that edge.
- R2: With `ASYNC_CLR`=0, `clr_n` low at a rising edge makes `q` 0 after that edge, whatever `load_n`, `cnt_en` and `chain_en` are. Between edges a low `clr_n` leaves `q` unchanged. While `clr_n` is high it has no effect.
- R3: With `ASYNC_CLR`=1, `q` goes to 0 as soon as `clr_n` goes low, without a clock edge, and stays 0 while `clr_n` is low. Counting resumes at the first rising edge after `clr_n` returns high.
- R4: With `clr_n` high, `load_n` low at a rising edge copies `preset` into `q`, whatever the two enables are. When `clr_n` and `load_n` are both low, the clear wins.
- R5: With `clr_n`, `load_n`, `cnt_en` and `chain_en` all high at a rising edge, and `q` below its last state, `q` rises by one.
- R6: With `clr_n` and `load_n` high and either enable low at a rising edge, `q` holds its value.
- R7: A count step from the last state goes to 0 (9 to 0 when `DECADE`=1, 15 to 0 when `DECADE`=0). In decade mode a count step from any state of 9 or above goes to 0.
- R8: `carry_out` equals `chain_en` AND (`q` equals the last state), combinationally in the same cycle. `cnt_en` has no effect on it, and in decade mode it is low for states 10 to 15.
- R9: In decade mode, a preset from 10 to 15 is loaded unchanged.
- R10: Three stages that share clock, load and `cnt_en`, with each carry feeding the next stage's `chain_en`, count as one 3-digit decade counter (modulo 1000) or one 12-bit binary counter (modulo 4096).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All register updates happen on its rising edge. |
| rst | input | 1 | Synchronous active-high reset that zeroes the count. |
| clr_n | input | 1 | Active-low clear. It is synchronous or asynchronous according to `ASYNC_CLR`. |
| load_n | input | 1 | Active-low parallel load of `preset`. |
| preset | input | WIDTH | Value that is loaded when `load_n` is low. |
| cnt_en | input | 1 | Count enable. It does not affect the carry. |
| chain_en | input | 1 | Count enable that also gates `carry_out`. |
| q | output | WIDTH | Current count. |
| carry_out | output | 1 | High at the last state while `chain_en` is high. |

## Verification
Load, count, hold, the synchronous clear and the reset all register their result on the edge where the controls are sampled. The bench changes inputs on the falling edge and reads `q` 1 ns after the next rising edge. `carry_out` has no register, so the bench reads it in the same cycle, including right after `chain_en` toggles with no clock edge. For the asynchronous clear, the bench drops `clr_n` between edges and reads `q` half a nanosecond later, before any edge. At the same moment it confirms that the synchronous variant still shows its old value until the next edge. Each step of the cascade is checked one edge after the step, because the carries settle within the cycle.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

    // Operation chosen for the next clock edge, highest priority last
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Control inputs of one stage as a group
    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic cnt_en;
        logic chain_en;
    } cnt_ctl_t;

    // Last state before wrap: 9 for decade, all ones for binary
    function automatic int last_state(bit decade, int width);
        return decade ? 9 : (1 << width) - 1;
    endfunction

endpackage

// File: rtl/casc_cnt_decode.sv
module casc_cnt_decode
    import casc_cnt_pkg::*;
(
    input  cnt_ctl_t ctl,
    output cnt_op_e  op
);

    // Priority: clear, then load, then count (both enables), else hold
    always_comb begin
        if (!ctl.clr_n)
            op = OP_CLEAR;
        else if (!ctl.load_n)
            op = OP_LOAD;
        else if (ctl.cnt_en && ctl.chain_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/casc_cnt_step.sv
module casc_cnt_step
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] preset,
    input  cnt_op_e          op,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(last_state(DECADE, WIDTH));

    // Any state at or past the last one steps to zero
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = (q >= TERM) ? '0 : q + 1'b1;
            default:  nxt = q;
        endcase
    end

endmodule

// File: rtl/casc_cnt_carry.sv
module casc_cnt_carry
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(last_state(DECADE, WIDTH));

    // Look-ahead carry: no register, so the next stage sees it this cycle
    assign carry_out = chain_en && (q == TERM);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import casc_cnt_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter bit DECADE    = 1'b1,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] TERM = WIDTH'(last_state(DECADE, WIDTH));

    cnt_ctl_t         ctl;
    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;

    assign ctl = {clr_n, load_n, cnt_en, chain_en};

    casc_cnt_decode u_dec (
        .ctl (ctl),
        .op  (op)
    );

    casc_cnt_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
        .q      (q),
        .preset (preset),
        .op     (op),
        .nxt    (nxt)
    );

    casc_cnt_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
        .q         (q),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (rst)
        !chain_en |-> !carry_out);                                      // R8
    AST_CARRY_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        (chain_en && q == TERM) |-> carry_out);                         // R8

    generate
        if (ASYNC_CLR) begin : g_async
            // Clear acts at once; release takes effect at the next edge
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    q <= '0;
                else if (rst)
                    q <= '0;
                else
                    q <= nxt;
            end

            AST_ASYNC_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
                !clr_n |-> q == '0);                                    // R3
        end else begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else
                    q <= nxt;
            end

            AST_SYNC_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
                !clr_n |=> q == '0);                                    // R2
            AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
                (clr_n && !load_n) |=> q == $past(preset));             // R4
            AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
                (clr_n && load_n && cnt_en && chain_en && q < TERM)
                |=> q == $past(q) + 1'b1);                              // R5
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                (clr_n && load_n && !(cnt_en && chain_en)) |=> $stable(q)); // R6
            AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
                (clr_n && load_n && cnt_en && chain_en && q >= TERM)
                |=> q == '0);                                           // R7
        end
    endgenerate

endmodule

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;

    logic       clk = 1'b0;
    logic       rst;
    logic       clr_n, load_n, pe, te;
    logic [3:0] preset;
    logic [3:0] q0, q1;
    logic       c0, c1;

    // Cascade controls
    logic        c_ld, c_pe, c_te;
    logic [11:0] pre_a, pre_b;
    logic [11:0] qa, qb;
    logic [2:0]  ca, cb;
    logic [3:0]  ta, tb;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    // Decade, synchronous clear
    casc_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u0 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .preset(preset),
        .cnt_en(pe), .chain_en(te), .q(q0), .carry_out(c0));

    // Binary, asynchronous clear
    casc_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u1 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .preset(preset),
        .cnt_en(pe), .chain_en(te), .q(q1), .carry_out(c1));

    assign ta[0] = c_te;
    assign tb[0] = c_te;
    for (genvar k = 0; k < 3; k++) begin : g_chain
        casc_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_a (
            .clk(clk), .rst(rst), .clr_n(1'b1), .load_n(c_ld),
            .preset(pre_a[4*k +: 4]), .cnt_en(c_pe), .chain_en(ta[k]),
            .q(qa[4*k +: 4]), .carry_out(ca[k]));
        casc_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_b (
            .clk(clk), .rst(rst), .clr_n(1'b1), .load_n(c_ld),
            .preset(pre_b[4*k +: 4]), .cnt_en(c_pe), .chain_en(tb[k]),
            .q(qb[4*k +: 4]), .carry_out(cb[k]));
        assign ta[k+1] = ca[k];
        assign tb[k+1] = cb[k];
    end

    // Row: [13]rst [12]clr_n [11]load_n [10]pe [9]te [8:5]preset [4:1]u0 q [0]u0 carry
    localparam int NV = 19;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0},  // R1 reset state
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0},  // R4 load, enables low
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0},  // R5
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1},  // R5, R8 carry at 9
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 9 -> 0
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0},  // R6 cnt_en low
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9,  4'd9,  1'b1},  // R8 cnt_en low, carry up
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd9,  1'b0},  // R6 and R8 chain_en low
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd9,  1'b1},  // R6
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0},  // R9 preset 12, no carry
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 12 -> 0
        {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 4'd0,  1'b0},  // R4 clear beats load
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b1},  // R4 load beats count
        {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R2 clear beats count
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3,  4'd3,  1'b0},  // R4
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd4,  1'b0},  // R5
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd14, 4'd14, 1'b0},  // R9 preset 14
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 decade 14 -> 0, binary 15
        {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0}   // R7 binary 15 -> 0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference behaviour of one stage, written from the requirements
    function automatic int ref_next(int cur, logic r, logic cl, logic ld, logic en1,
                                    logic en2, int pre, bit dec);
        int last;
        last = dec ? 9 : 15;
        if (r || !cl)      return 0;
        if (!ld)           return pre;
        if (en1 && en2)    return (cur >= last) ? 0 : cur + 1;
        return cur;
    endfunction

    function automatic string row_tag(logic [13:0] v);
        if (v[13])      return "R1";
        if (!v[12])     return "R2";
        if (!v[11])     return "R4";
        if (v[10] && v[9]) return "R5";
        return "R6";
    endfunction

    function automatic int bcd3(logic [11:0] v);
        return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int mb;
        int ma;
        rst = 1'b1; clr_n = 1'b1; load_n = 1'b1; pe = 1'b0; te = 1'b0; preset = '0;
        c_ld = 1'b1; c_pe = 1'b0; c_te = 1'b0; pre_a = '0; pre_b = '0;
        mb = 0;
        repeat (2) @(posedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rst = VEC[i][13]; clr_n = VEC[i][12]; load_n = VEC[i][11];
            pe = VEC[i][10]; te = VEC[i][9]; preset = VEC[i][8:5];
            @(posedge clk);
            #1;
            mb = ref_next(mb, rst, clr_n, load_n, pe, te, int'(preset), 1'b0);
            chk(row_tag(VEC[i]), 16'(q0), 16'(VEC[i][4:1]));
            chk("R8 decade carry", 16'(c0), 16'(VEC[i][0]));
            chk({row_tag(VEC[i]), " R7 binary"}, 16'(q1), 16'(mb));
            chk("R8 binary carry", 16'(c1), 16'(te && mb == 15));
        end

        // R3: asynchronous clear without an edge; R2: synchronous one waits
        @(negedge clk);
        load_n = 1'b0; preset = 4'd6; pe = 1'b0; te = 1'b0;
        @(posedge clk); #1;
        chk("R4 load 6 decade", 16'(q0), 16'd6);
        chk("R4 load 6 binary", 16'(q1), 16'd6);
        clr_n = 1'b0; load_n = 1'b1;
        #0.5;
        chk("R3 async clear immediate", 16'(q1), 16'd0);
        chk("R2 sync clear waits for edge", 16'(q0), 16'd6);
        @(posedge clk); #1;
        chk("R2 sync clear at edge", 16'(q0), 16'd0);
        chk("R3 async clear held", 16'(q1), 16'd0);
        @(negedge clk);
        clr_n = 1'b1; pe = 1'b1; te = 1'b1;
        @(posedge clk); #1;
        chk("R3 count resumes after release", 16'(q1), 16'd1);
        chk("R5 count after sync clear", 16'(q0), 16'd1);

        // R1: reset in the middle of counting
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset decade", 16'(q0), 16'd0);
        chk("R1 reset binary", 16'(q1), 16'd0);
        @(negedge clk); rst = 1'b0;

        // R8: carry follows chain_en within the cycle, cnt_en ignored
        load_n = 1'b0; preset = 4'd9; pe = 1'b0; te = 1'b0;
        @(posedge clk); #1;
        load_n = 1'b1;
        chk("R8 carry low with chain_en low", 16'(c0), 16'd0);
        te = 1'b1; #0.5;
        chk("R8 carry rises with chain_en", 16'(c0), 16'd1);
        chk("R8 binary no carry at 9", 16'(c1), 16'd0);
        pe = 1'b1; #0.5;
        chk("R8 cnt_en has no effect", 16'(c0), 16'd1);
        te = 1'b0; #0.5;
        chk("R8 carry falls with chain_en", 16'(c0), 16'd0);
        pe = 1'b0;
        @(negedge clk);
        load_n = 1'b0; preset = 4'd15;
        @(posedge clk); #1;
        load_n = 1'b1; te = 1'b1; #0.5;
        chk("R8 binary carry at 15", 16'(c1), 16'd1);
        chk("R8 decade no carry at 15", 16'(c0), 16'd0);
        chk("R9 decade keeps preset 15", 16'(q0), 16'd15);

        // R10: three-stage cascades
        @(negedge clk);
        te = 1'b0;
        c_ld = 1'b0; pre_a = 12'h997; pre_b = 12'hFFD;
        @(posedge clk); #1;
        ma = 997; mb = 4093;
        chk("R10 cascade load decade", 16'(bcd3(qa)), 16'(ma));
        chk("R10 cascade load binary", 16'(qb), 16'(mb));
        @(negedge clk);
        c_ld = 1'b1; c_pe = 1'b1; c_te = 1'b1;
        for (int s = 0; s < 5; s++) begin
            @(posedge clk); #1;
            ma = (ma + 1) % 1000;
            mb = (mb + 1) % 4096;
            chk("R10 cascade step decade", 16'(bcd3(qa)), 16'(ma));
            chk("R10 cascade step binary", 16'(qb), 16'(mb));
        end
        @(negedge clk); c_pe = 1'b0;
        @(posedge clk); #1;
        chk("R10 cascade hold on cnt_en", 16'(bcd3(qa)), 16'(ma));
        chk("R10 cascade hold binary", 16'(qb), 16'(mb));
        @(negedge clk); c_pe = 1'b1; c_te = 1'b0;
        @(posedge clk); #1;
        chk("R10 cascade hold on chain_en", 16'(bcd3(qa)), 16'(ma));
        chk("R10 cascade hold binary te", 16'(qb), 16'(mb));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule